// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two WIDTH-bit operands over several clock cycles and returns a 2*WIDTH-bit product. A single-cycle `start_i` pulse hands over the operands while the block is idle. The block then works through the multiplier one bit per clock. In each step it adds the multiplicand into a running sum when the current bit is set, then shifts the sum. After WIDTH steps it raises `done_o` for one cycle, and the result appears on `product_o`.

A mode input chooses between unsigned and two's-complement operation. In signed mode each negative operand is first replaced by its magnitude, held as an unsigned WIDTH-bit value. The unsigned core multiplies the magnitudes. The product is negated when exactly one operand was negative. Because the magnitude is unsigned, the most negative input maps to 2^(WIDTH-1), and the product of two such inputs comes out correct.

`busy_o` shows when the block cannot accept work, and `!busy_o` acts as the ready signal. Operands and mode are registered when a start is accepted. A start that arrives while busy is dropped.

Top module: `shift_add_mul`

## Requirements
- R1: During and right after a synchronous active-low reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A cycle with `start_i`=1 and `busy_o`=0 is accepted, and `busy_o` is 1 in the following cycle.
- R3: `start_i` is ignored while `busy_o` is 1. It starts no new operation and does not alter the operation in progress.
- R4: `done_o` is 1 for exactly one cycle, WIDTH clock edges after the accepting edge. `busy_o` drops in that same cycle.
- R5: With `signed_i`=0 the result is the unsigned product of the operands modulo 2^(2*WIDTH). For example, 1011 times 1101 gives 10001111.
- R6: With `signed_i`=1 the operands and the result are two's complement, and the result is the exact signed product in 2*WIDTH bits.
- R7: In signed mode the most negative operand is handled exactly. (-2^(WIDTH-1)) squared gives +2^(2*WIDTH-2), and times -1 gives +2^(WIDTH-1).
- R8: `product_o` keeps its value from one `done_o` pulse until the next.
- R9: Operands and `signed_i` are sampled only in the accepting cycle. Later changes on these inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| a_i | input | WIDTH | Multiplicand |
| b_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress; start is ignored |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Result of the last completed multiply |

## Verification
The checker watches the handshake and timing on every cycle: acceptance raising busy, the one-cycle done pulse that lines up with busy falling exactly WIDTH edges after acceptance, and a held result between pulses. It also holds a behavioural product captured at acceptance and compares it with the output at every done pulse.

Only the bench scenarios can show the full arithmetic picture. The bench sweeps every operand pair in both modes at a 4-bit width and checks the named corner values. While each operation runs, it drives a competing start with different operands and the opposite mode, which shows that the in-flight result is unaffected.

// File: rtl/mul_pkg.sv
// Shared definitions for the shift-add multiplier.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package mul_pkg;

    // Operand-side sign handling selector
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;

    // Number of operands handled by the sign-preparation stage
    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/mul_magnitude.sv
// Converts one operand into an unsigned magnitude plus a sign flag.
// In unsigned mode the operand passes through and the sign flag is 0.
// Assumes: the most negative value maps to 2^(WIDTH-1), which fits
// in WIDTH unsigned bits, so no extra width is required.
module mul_magnitude
    import mul_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_i,
    input  mul_mode_e        mode_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);

    // Magnitude and sign from the operand and the mode
    always_comb begin
        neg_o = (mode_i == MODE_SIGNED) && op_i[WIDTH-1];
        mag_o = neg_o ? (~op_i + {{(WIDTH-1){1'b0}}, 1'b1}) : op_i;
    end

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer for the multiplier: accepts a start when idle, counts
// WIDTH steps, and flags the last step.
// Assumes: WIDTH >= 2; start during busy is dropped on purpose.
module mul_ctrl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic accept_o,
    output logic step_o,
    output logic last_o
);

    localparam int unsigned CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] step_cnt;

    // Handshake decode: accept only while idle
    always_comb begin
        accept_o = start_i && !busy_o;
        step_o   = busy_o;
        last_o   = busy_o && (step_cnt == LAST_CNT);
    end

    // Busy flag and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            step_cnt <= '0;
        end else if (accept_o) begin
            busy_o   <= 1'b1;
            step_cnt <= '0;
        end else if (busy_o) begin
            step_cnt <= step_cnt + 1'b1;
            if (last_o) begin
                busy_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mul_datapath.sv
// Unsigned shift-add core. The multiplier sits in the low half of a
// combined register and is consumed LSB first. The running sum sits in
// the high half, with one extra bit to catch the carry.
// Assumes: load and step are never asserted together.
module mul_datapath #(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] next_prod_o
);

    localparam int unsigned HI_W = WIDTH + 1;

    logic [HI_W-1:0]  acc_hi;
    logic [WIDTH-1:0] acc_lo;
    logic [WIDTH-1:0] mcand_q;
    logic [HI_W-1:0]  partial;
    logic [HI_W-1:0]  sum;

    // Partial product for the current multiplier bit, and the new sum
    always_comb begin
        partial     = acc_lo[0] ? {1'b0, mcand_q} : '0;
        sum         = acc_hi + partial;
        next_prod_o = {sum[WIDTH:0], acc_lo[WIDTH-1:1]};
    end

    // Load the operands, or add-and-shift one step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi  <= '0;
            acc_lo  <= '0;
            mcand_q <= '0;
        end else if (load_i) begin
            acc_hi  <= '0;
            acc_lo  <= mplier_i;
            mcand_q <= mcand_i;
        end else if (step_i) begin
            acc_hi  <= {1'b0, sum[HI_W-1:1]};
            acc_lo  <= {sum[0], acc_lo[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/shift_add_mul.sv
// Multi-cycle multiplier, unsigned or two's complement. Signed operands
// are turned into magnitudes, multiplied by the unsigned core, and the
// product is negated when the operand signs differ.
// Assumes: one operation at a time; result held until the next done.
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               signed_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int unsigned PROD_W = 2 * WIDTH;

    logic [WIDTH-1:0]        ops   [NUM_OPERANDS];
    logic [WIDTH-1:0]        mags  [NUM_OPERANDS];
    logic [NUM_OPERANDS-1:0] negs;
    mul_mode_e               mode;
    logic                    accept;
    logic                    step;
    logic                    last;
    logic                    flip_q;
    logic [PROD_W-1:0]       next_prod;

    // Operand routing into the sign-preparation stage
    always_comb begin
        ops[0] = a_i;
        ops[1] = b_i;
        mode   = signed_i ? MODE_SIGNED : MODE_UNSIGNED;
    end

    // One magnitude converter per operand
    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_mag
        mul_magnitude #(.WIDTH(WIDTH)) u_mag (
            .op_i   (ops[g]),
            .mode_i (mode),
            .mag_o  (mags[g]),
            .neg_o  (negs[g])
        );
    end

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .step_o   (step),
        .last_o   (last)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .step_i      (step),
        .mcand_i     (mags[0]),
        .mplier_i    (mags[1]),
        .next_prod_o (next_prod)
    );

    // Result sign captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_q <= 1'b0;
        end else if (accept) begin
            flip_q <= ^negs;
        end
    end

    // Final result register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= last;
            if (last) begin
                product_o <= flip_q ? (~next_prod + 1'b1) : next_prod;
            end
        end
    end

endmodule

// File: rtl/shift_add_mul_checker.sv
// Property checker for shift_add_mul, attached by bind.
// Assumes: observes ports only; keeps its own step counter and a
// behavioural product captured at acceptance.
module shift_add_mul_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               signed_i,
    input logic [WIDTH-1:0]   a_i,
    input logic [WIDTH-1:0]   b_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int unsigned PW = 2 * WIDTH;
    localparam int unsigned CW = $clog2(WIDTH + 2);

    logic [CW-1:0] edges_q;
    logic [PW-1:0] ref_q;
    logic          seen_q;
    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;

    // Operand extension for the reference product
    always_comb begin
        ext_a = signed_i ? {{WIDTH{a_i[WIDTH-1]}}, a_i} : {{WIDTH{1'b0}}, a_i};
        ext_b = signed_i ? {{WIDTH{b_i[WIDTH-1]}}, b_i} : {{WIDTH{1'b0}}, b_i};
    end

    // Edges since acceptance and reference product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
            ref_q   <= '0;
            seen_q  <= 1'b0;
        end else if (start_i && !busy_o) begin
            edges_q <= '0;
            ref_q   <= ext_a * ext_b;
            seen_q  <= 1'b1;
        end else if (busy_o) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (edges_q < CW'(WIDTH)));

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seen_q && edges_q == CW'(WIDTH)));

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (!done_o |-> $stable(product_o)));

    // R5
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == ref_q));

endmodule

bind shift_add_mul shift_add_mul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .signed_i  (signed_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
// Exhaustive bench at WIDTH=4: every operand pair in both modes, plus
// named corner cases, with a competing start injected during each run.
module test_shift_add_mul;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int checks = 0;
    int fails  = 0;
    logic [PW-1:0] prev_prod = '0;

    always #2.5 clk = ~clk;

    shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .signed_i  (signed_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] model(input int a, input int b, input bit sgn);
        int sa = (sgn && a >= (1 << (W - 1))) ? a - (1 << W) : a;
        int sb = (sgn && b >= (1 << (W - 1))) ? b - (1 << W) : b;
        return PW'(sa * sb);
    endfunction

    // One multiply with a rejected start injected while busy (R3, R9)
    task automatic run_op(input int a, input int b, input bit sgn, input string tag);
        logic [PW-1:0] exp = model(a, b, sgn);
        @(negedge clk);
        start_i = 1'b1; a_i = W'(a); b_i = W'(b); signed_i = sgn;
        @(negedge clk);
        check(busy_o === 1'b1, "R2 busy after accept", busy_o, 1);
        check(product_o === prev_prod, "R8 result held", product_o, prev_prod);
        start_i = 1'b1; a_i = ~W'(a); b_i = W'(b + 5); signed_i = !sgn;
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (k < W) begin
                check(done_o === 1'b0, "R4 no early done", done_o, 0);
                check(busy_o === 1'b1, "R3 still busy", busy_o, 1);
            end else begin
                check(done_o === 1'b1 && busy_o === 1'b0, "R4 done at WIDTH edges", {done_o, busy_o}, 2);
                check(product_o === exp, tag, product_o, exp);
            end
        end
        prev_prod = exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o === 1'b0, "R1 busy in reset", busy_o, 0);
        check(done_o === 1'b0, "R1 done in reset", done_o, 0);
        check(product_o === '0, "R1 product in reset", product_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset", {busy_o, done_o}, 0);

        run_op(11, 13, 1'b0, "R5 11x13=143");
        run_op(8, 8, 1'b1, "R7 min squared");
        run_op(8, 15, 1'b1, "R7 min times -1");
        run_op(8, 7, 1'b1, "R7 min times max");
        run_op(15, 15, 1'b1, "R6 -1 times -1");
        run_op(0, 8, 1'b1, "R6 zero times min");
        run_op(15, 15, 1'b0, "R5 max unsigned");

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    run_op(a, b, m[0], m[0] ? "R6 signed sweep (R9 mode)" : "R5 unsigned sweep (R9 mode)");
                end
            end
        end

        repeat (3) @(negedge clk);
        check(product_o === prev_prod && done_o === 1'b0, "R8 idle hold", product_o, prev_prod);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule